// File: doc/BRIEF.md
# Output Test Pattern Generator

This block sits between a converter's data path and its output formatting. On every sample clock it forwards either the converter word or one of several synthetic 11-bit test words. A 4-bit mode code selects the source. The choices are fixed levels (midscale, positive full scale, negative full scale), two alternating words (a checkerboard and an all-ones/all-zeros toggle), and two maximal-length pseudo-random sequences, a short one and a long one. Whatever source is selected then passes through the same number-format and inversion stage. A receiving system therefore sees test words coded exactly as live data would be.

A restart input holds every generator at its starting point. Changing the mode code also restarts the generators, so a newly selected sequence always begins at a known word. This lets a receiver that runs its own copy of the sequence lock on without searching. The output is registered: the word produced for the inputs present at one rising clock edge appears right after that edge.

Top module: `tpg_pattern_gen`

## Requirements
- R1: While reset is held, and right after the reset edge, `out_word` is all zeros.
- R2: With mode 0000, `out_word` carries `conv_data` from the previous rising edge, with one clock of latency.
- R3: In offset-binary coding, mode 0001 outputs 0x400, mode 0010 outputs 0x7FF, and mode 0011 outputs 0x000.
- R4: Mode 0100 outputs 0x555 on its first sample, then alternates between 0x2AA and 0x555.
- R5: Mode 0111 outputs 0x7FF on its first sample, then alternates between 0x000 and 0x7FF.
- R6: Mode 0110 outputs a short pseudo-random sequence from a 9-bit register s, polynomial x^9+x^5+1. The register is seeded all ones. Each step shifts s left and inserts s[8]^s[4] at bit 0. The output word is {s[8:0], 2'b00}. The sequence repeats every 511 samples.
- R7: Mode 0101 outputs a long pseudo-random sequence from a 23-bit register t, polynomial x^23+x^18+1. The register is seeded all ones. Each step shifts t left and inserts t[22]^t[17] at bit 0. The output word is t[22:12].
- R8: Codes 1000 through 1111 behave exactly like mode 0000.
- R9: When the mode code differs from the code at the previous edge, the first word produced is the starting word: the seed for the random sequences, phase 0 for the alternating patterns.
- R10: While `gen_restart` is high, the generators stay at their starting word. Stepping resumes on the first edge after it drops.
- R11: When `fmt_twos` is 1, the word's most significant bit (bit 10) is inverted. This converts offset binary to twos complement and applies to converter data and test words alike.
- R12: When `out_invert` is 1, all output bits are inverted, after the format step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| conv_data | input | 11 | Converter word, offset binary |
| test_mode | input | 4 | Source select code |
| gen_restart | input | 1 | Hold the generators at their starting word |
| fmt_twos | input | 1 | 1 selects twos complement coding |
| out_invert | input | 1 | 1 inverts every output bit |
| out_word | output | 11 | Registered, formatted output word |

## Verification
A corrupted generator register shows at the ports on the very next sample. Every bit of the short sequence's register is visible in the output word, and the long sequence exposes its top eleven bits. A stuck feedback tap or a wrong seed therefore breaks the comparison against a reference shift-register model within a few samples after a restart. A bad phase register in the alternating patterns flips the expected word on the first sample. A missed restart on a mode change shows as a first word that differs from the seed. The period check on the short sequence separately catches a non-maximal polynomial, which a word-by-word check alone might only reveal after hundreds of samples.

// File: rtl/tpg_pkg.sv
package tpg_pkg;

   localparam int TPG_MODE_W = 4;

   typedef enum logic [TPG_MODE_W-1:0] {
      TPG_OFF    = 4'b0000,
      TPG_MID    = 4'b0001,
      TPG_POS_FS = 4'b0010,
      TPG_NEG_FS = 4'b0011,
      TPG_CHECK  = 4'b0100,
      TPG_PN_LNG = 4'b0101,
      TPG_PN_SHT = 4'b0110,
      TPG_TOGGLE = 4'b0111
   } tpg_mode_e;

endpackage

// File: rtl/tpg_lfsr.sv
module tpg_lfsr #(
   parameter int LEN = 9,
   parameter int TAP = 5,
   parameter int DW  = 11
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   output logic [DW-1:0] word
);

   logic [LEN-1:0] state;
   logic [LEN-1:0] eff;
   logic           fb;

   // starting value wins over the running state in the same cycle
   assign eff = load ? {LEN{1'b1}} : state;
   assign fb  = eff[LEN-1] ^ eff[TAP-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= {LEN{1'b1}};
      else        state <= {eff[LEN-2:0], fb};
   end

   generate
      if (LEN >= DW) begin : g_slice
         assign word = eff[LEN-1 -: DW];
      end else begin : g_pad
         assign word = {eff, {(DW-LEN){1'b0}}};
      end
   endgenerate

endmodule

// File: rtl/tpg_alt.sv
module tpg_alt #(
   parameter int DW = 11
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   output logic [DW-1:0] chk_word,
   output logic [DW-1:0] tgl_word
);

   logic          phase;
   logic          eff;
   logic [DW-1:0] even_bits;

   assign eff = load ? 1'b0 : phase;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) phase <= 1'b0;
      else        phase <= ~eff;
   end

   generate
      for (genvar i = 0; i < DW; i++) begin : g_bits
         assign even_bits[i] = ((i % 2) == 0);
      end
   endgenerate

   assign chk_word = eff ? ~even_bits : even_bits;
   assign tgl_word = {DW{~eff}};

endmodule

// File: rtl/tpg_fmt.sv
module tpg_fmt #(
   parameter int DW = 11
) (
   input  logic [DW-1:0] din,
   input  logic          twos,
   input  logic          inv,
   output logic [DW-1:0] dout
);

   logic [DW-1:0] coded;

   assign coded = {din[DW-1] ^ twos, din[DW-2:0]};
   assign dout  = coded ^ {DW{inv}};

endmodule

// File: rtl/tpg_pattern_gen.sv
module tpg_pattern_gen
   import tpg_pkg::*;
#(
   parameter int DW       = 11,
   parameter int PN_S_LEN = 9,
   parameter int PN_S_TAP = 5,
   parameter int PN_L_LEN = 23,
   parameter int PN_L_TAP = 18
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [DW-1:0]         conv_data,
   input  logic [TPG_MODE_W-1:0] test_mode,
   input  logic                  gen_restart,
   input  logic                  fmt_twos,
   input  logic                  out_invert,
   output logic [DW-1:0]         out_word
);

   generate
      if (DW < 2) begin : g_err_dw
         $error("tpg_pattern_gen: DW must be at least 2");
      end
      if (PN_S_TAP < 1 || PN_S_TAP >= PN_S_LEN) begin : g_err_stap
         $error("tpg_pattern_gen: short tap out of range");
      end
      if (PN_L_TAP < 1 || PN_L_TAP >= PN_L_LEN) begin : g_err_ltap
         $error("tpg_pattern_gen: long tap out of range");
      end
      if (PN_L_LEN < DW) begin : g_err_llen
         $error("tpg_pattern_gen: long register narrower than word");
      end
   endgenerate

   localparam logic [DW-1:0] W_MID = {1'b1, {(DW-1){1'b0}}};

   logic [TPG_MODE_W-1:0] mode_q;
   logic                  load;
   logic [DW-1:0]         pn_s_word, pn_l_word, chk_word, tgl_word;
   logic [DW-1:0]         sel_word, fmt_word;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mode_q <= '0;
      else        mode_q <= test_mode;
   end

   assign load = gen_restart | (test_mode != mode_q);

   tpg_lfsr #(.LEN(PN_S_LEN), .TAP(PN_S_TAP), .DW(DW)) u_pn_short (
      .clk(clk), .rst_n(rst_n), .load(load), .word(pn_s_word));

   tpg_lfsr #(.LEN(PN_L_LEN), .TAP(PN_L_TAP), .DW(DW)) u_pn_long (
      .clk(clk), .rst_n(rst_n), .load(load), .word(pn_l_word));

   tpg_alt #(.DW(DW)) u_alt (
      .clk(clk), .rst_n(rst_n), .load(load),
      .chk_word(chk_word), .tgl_word(tgl_word));

   always_comb begin
      case (tpg_mode_e'(test_mode))
         TPG_MID:    sel_word = W_MID;
         TPG_POS_FS: sel_word = {DW{1'b1}};
         TPG_NEG_FS: sel_word = {DW{1'b0}};
         TPG_CHECK:  sel_word = chk_word;
         TPG_PN_LNG: sel_word = pn_l_word;
         TPG_PN_SHT: sel_word = pn_s_word;
         TPG_TOGGLE: sel_word = tgl_word;
         default:    sel_word = conv_data;
      endcase
   end

   tpg_fmt #(.DW(DW)) u_fmt (
      .din(sel_word), .twos(fmt_twos), .inv(out_invert), .dout(fmt_word));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) out_word <= '0;
      else        out_word <= fmt_word;
   end

endmodule

// File: rtl/tpg_pattern_gen_chk.sv
module tpg_pattern_gen_chk #(
   parameter int DW = 11
) (
   input logic          clk,
   input logic          rst_n,
   input logic [DW-1:0] conv_data,
   input logic [3:0]    test_mode,
   input logic          gen_restart,
   input logic          fmt_twos,
   input logic          out_invert,
   input logic [DW-1:0] out_word
);

   localparam logic [DW-1:0] C_MID = {1'b1, {(DW-1){1'b0}}};
   localparam logic [DW-1:0] C_ONE = {DW{1'b1}};

   logic plain;
   assign plain = !fmt_twos && !out_invert;

   AST_OFF_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      (test_mode == 4'd0 && plain) |=> out_word == $past(conv_data)); // R2

   AST_MIDSCALE: assert property (@(posedge clk) disable iff (!rst_n)
      (test_mode == 4'd1 && plain) |=> out_word == C_MID); // R3

   AST_POS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      (test_mode == 4'd2 && plain) |=> out_word == C_ONE); // R3

   AST_NEG_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      (test_mode == 4'd3 && plain) |=> out_word == '0); // R3

   AST_CHECK_ALT: assert property (@(posedge clk) disable iff (!rst_n)
      (test_mode == 4'd4 && $past(test_mode) == 4'd4 && !gen_restart
       && $stable(fmt_twos) && $stable(out_invert))
      |=> (out_word ^ $past(out_word)) == C_ONE); // R4

   AST_UNUSED_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (test_mode[3] && plain) |=> out_word == $past(conv_data)); // R8

   AST_RESTART_SEED: assert property (@(posedge clk) disable iff (!rst_n)
      (gen_restart && test_mode == 4'd5 && plain) |=> out_word == C_ONE); // R10

   AST_TWOS_MID: assert property (@(posedge clk) disable iff (!rst_n)
      (test_mode == 4'd1 && fmt_twos && !out_invert) |=> out_word == '0); // R11

   AST_INVERT_FS: assert property (@(posedge clk) disable iff (!rst_n)
      (test_mode == 4'd2 && !fmt_twos && out_invert) |=> out_word == '0); // R12

endmodule

bind tpg_pattern_gen tpg_pattern_gen_chk #(.DW(DW)) u_chk (
   .clk(clk), .rst_n(rst_n), .conv_data(conv_data), .test_mode(test_mode),
   .gen_restart(gen_restart), .fmt_twos(fmt_twos), .out_invert(out_invert),
   .out_word(out_word));

// File: tb/tb_tpg_pattern_gen.sv
module tb_tpg_pattern_gen;

   localparam int DW = 11;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [DW-1:0] conv_data = '0;
   logic [3:0]    test_mode = '0;
   logic          gen_restart = 1'b0;
   logic          fmt_twos = 1'b0;
   logic          out_invert = 1'b0;
   logic [DW-1:0] out_word;

   int tests = 0;
   int fails = 0;
   bit done = 0;

   always #4 clk = ~clk;

   tpg_pattern_gen dut (
      .clk(clk), .rst_n(rst_n), .conv_data(conv_data), .test_mode(test_mode),
      .gen_restart(gen_restart), .fmt_twos(fmt_twos), .out_invert(out_invert),
      .out_word(out_word));

   // reference model state
   logic [3:0]  m_mode_q = '0;
   logic [8:0]  m9  = '1;
   logic [22:0] m23 = '1;
   logic        mph = 1'b0;

   function automatic logic [8:0] step9(input logic [8:0] s);
      return {s[7:0], s[8] ^ s[4]};
   endfunction

   function automatic logic [22:0] step23(input logic [22:0] s);
      return {s[21:0], s[22] ^ s[17]};
   endfunction

   function automatic string req_of(input logic [3:0] md);
      case (md)
         4'd0: return "R2";
         4'd1, 4'd2, 4'd3: return "R3";
         4'd4: return "R4";
         4'd5: return "R7";
         4'd6: return "R6";
         4'd7: return "R5";
         default: return "R8";
      endcase
   endfunction

   task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: out_word actual=0x%03h expected=0x%03h", tag, act, exp);
      end
   endtask

   // apply inputs, wait one edge, compare against the model
   task automatic tick(input logic [3:0] md, input logic [DW-1:0] d, input logic rg,
                       input logic tw, input logic iv, input string tag);
      logic          ld;
      logic [8:0]    e9;
      logic [22:0]   e23;
      logic          eph;
      logic [DW-1:0] raw, exp;
      ld  = rg || (md != m_mode_q);
      e9  = ld ? 9'h1FF : m9;
      e23 = ld ? 23'h7FFFFF : m23;
      eph = ld ? 1'b0 : mph;
      case (md)
         4'd1: raw = 11'h400;
         4'd2: raw = 11'h7FF;
         4'd3: raw = 11'h000;
         4'd4: raw = eph ? 11'h2AA : 11'h555;
         4'd5: raw = e23[22:12];
         4'd6: raw = {e9, 2'b00};
         4'd7: raw = eph ? 11'h000 : 11'h7FF;
         default: raw = d;
      endcase
      exp = {raw[10] ^ tw, raw[9:0]} ^ {DW{iv}};
      test_mode = md; conv_data = d; gen_restart = rg; fmt_twos = tw; out_invert = iv;
      @(posedge clk); #2;
      check(tag, out_word, exp);
      m9 = step9(e9); m23 = step23(e23); mph = ~eph; m_mode_q = md;
   endtask

   logic [DW-1:0] hist [0:1099];

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         tests++; fails++;
         $display("FAIL watchdog: run did not finish, actual=timeout expected=done");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      // R1: reset state
      repeat (3) @(posedge clk);
      #2;
      check("R1", out_word, '0);
      rst_n = 1'b1;
      check("R1", out_word, '0);

      // directed fixed words and formatting
      tick(4'd1, 11'h0, 0, 0, 0, "R3");
      tick(4'd2, 11'h0, 0, 0, 0, "R3");
      tick(4'd3, 11'h0, 0, 0, 0, "R3");
      tick(4'd1, 11'h0, 0, 1, 0, "R11");
      tick(4'd0, 11'h123, 0, 1, 0, "R11");
      tick(4'd3, 11'h0, 0, 0, 1, "R12");
      tick(4'd0, 11'h2C5, 0, 0, 1, "R12");
      tick(4'd9, 11'h0A7, 0, 0, 0, "R8");
      tick(4'd12, 11'h3F1, 0, 0, 0, "R8");
      tick(4'd15, 11'h511, 0, 0, 0, "R8");

      // R9: mode change restarts the selected source
      for (int k = 0; k < 3; k++) tick(4'd4, 11'h0, 0, 0, 0, "R4");
      tick(4'd7, 11'h0, 0, 0, 0, "R9");
      tick(4'd7, 11'h0, 0, 0, 0, "R5");
      for (int k = 0; k < 5; k++) tick(4'd5, 11'h0, 0, 0, 0, "R7");
      tick(4'd6, 11'h0, 0, 0, 0, "R9");
      for (int k = 0; k < 4; k++) tick(4'd6, 11'h0, 0, 0, 0, "R6");

      // R10: restart holds the seed, then stepping resumes
      tick(4'd6, 11'h0, 1, 0, 0, "R10");
      tick(4'd6, 11'h0, 1, 0, 0, "R10");
      tick(4'd6, 11'h0, 0, 0, 0, "R10");
      tick(4'd6, 11'h0, 0, 0, 0, "R10");
      tick(4'd5, 11'h0, 1, 0, 0, "R10");
      tick(4'd5, 11'h0, 0, 0, 0, "R10");

      // R6: period of the short sequence
      tick(4'd0, 11'h0, 0, 0, 0, "R2");
      for (int k = 0; k < 1100; k++) begin
         tick(4'd6, 11'h0, 0, 0, 0, "R6");
         hist[k] = out_word;
      end
      begin
         bit rep_ok = 1, uniq_ok = 1;
         for (int k = 0; k < 589; k++) if (hist[k+511] !== hist[k]) rep_ok = 0;
         for (int k = 1; k < 511; k++) if (hist[k] === hist[0]) uniq_ok = 0;
         check("R6", {10'd0, rep_ok}, 11'd1);
         check("R6", {10'd0, uniq_ok}, 11'd1);
      end

      // constrained random segments
      for (int seg = 0; seg < 80; seg++) begin
         logic [3:0] md;
         logic tw, iv;
         int len;
         md  = 4'($urandom_range(0, 15));
         tw  = 1'($urandom_range(0, 1));
         iv  = 1'($urandom_range(0, 1));
         len = $urandom_range(1, 40);
         for (int k = 0; k < len; k++) begin
            logic rg;
            rg = ($urandom_range(0, 15) == 0);
            tick(md, 11'($urandom), rg, tw, iv, rg ? "R10" : req_of(md));
         end
      end

      done = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule